// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block decides where a 32-bit MIPS-I style core fetches next. Each cycle it takes the current program counter, the decoded fields of the instruction (primary opcode, function code, the rt field used as a branch selector, the 16-bit immediate and the 26-bit jump index) and the two register operands. From these it resolves one of three things. It can take a conditional branch relative to the PC. It can take an absolute jump that stays inside the current 256 MB region. It can take a jump to a full 32-bit register value.

The block also reports whether control flow was redirected. For the linking forms it requests a write of the return address to register 31. One mode input sets the return address. With delayed branching on, the return address skips the instruction that always executes after the control transfer. With it off, the return address points at that next instruction.

All outputs are registered. A decision made from the inputs present at a rising clock edge appears on the outputs just after that edge.

Top module: `npc_unit`

## Requirements
- R1: If no jump is decoded and no branch condition holds, nextPc equals curPc + 4 (modulo 2^32) and taken is 0.
- R2: With opcode 4, the branch is taken when rsVal equals rtVal. With opcode 5, it is taken when they differ.
- R3: The compare-to-zero branches test rsVal alone as a signed two's-complement value. Opcode 6 is taken when rsVal <= 0 and opcode 7 when rsVal > 0. With opcode 1, rt field 0 or 16 is taken when rsVal < 0, and rt field 1 or 17 when rsVal >= 0.
- R4: A taken conditional branch sets nextPc to curPc + 4 + (sign-extended immediate shifted left by 2).
- R5: Opcode 2 and opcode 3 always set taken. nextPc is then {curPc[31:28], jIndex, 2'b00}.
- R6: Opcode 0 with function 0x08 or 0x09 always sets taken, and nextPc is then the full rsVal.
- R7: linkEn is 1 for exactly these cases, whether or not the branch is taken: opcode 3; opcode 0 with function 0x09; opcode 1 with rt field 16 or 17.
- R8: linkAddr equals curPc + 8 when delaySlotEn is 1 and curPc + 4 when it is 0, for every instruction.
- R9: Outputs are registered with one cycle of latency. While rstN is low, nextPc and linkAddr are 0, and taken and linkEn are 0.
- R10: Opcode 1 with any rt field other than 0, 1, 16 or 17, and opcode 0 with any other function code, cause no redirect and no link. nextPc is then curPc + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| delaySlotEn | input | 1 | 1 selects delayed-branch return address (PC+8) |
| curPc | input | 32 | Address of the instruction being resolved |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field for opcode 0 |
| rtSel | input | 5 | rt field, used as branch selector for opcode 1 |
| imm | input | 16 | Branch offset in instructions |
| jIndex | input | 26 | Region jump index |
| rsVal | input | 32 | First register operand |
| rtVal | input | 32 | Second register operand |
| nextPc | output | 32 | Resolved next fetch address |
| taken | output | 1 | Control flow redirected |
| linkEn | output | 1 | Request to write linkAddr to register 31 |
| linkAddr | output | 32 | Return address |

## Verification
The hardest cases to reach from the ports are the edges of the signed comparisons. These are rsVal equal to zero, to 0x80000000 and to 0x7FFFFFFF, and BEQ/BNE with equal operands. Random 32-bit operands almost never land there. The stimulus therefore draws operands from a pool of these boundary values for much of the time, and it forces rtVal to equal rsVal on a fixed share of cycles. The opcode and selector pools are weighted toward the control-flow encodings and the nearby non-branch codes of R10. Directed cases cover a PC that wraps past 2^32, the most negative offset, and a region jump from the top region.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int ADDR_W = 32;
  localparam int IMM_W = 16;
  localparam int IDX_W = 26;
  localparam int STEP = 4;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM = 6'd1;
  localparam logic [5:0] OP_J = 6'd2;
  localparam logic [5:0] OP_JAL = 6'd3;
  localparam logic [5:0] OP_BEQ = 6'd4;
  localparam logic [5:0] OP_BNE = 6'd5;
  localparam logic [5:0] OP_BLEZ = 6'd6;
  localparam logic [5:0] OP_BGTZ = 6'd7;
  localparam logic [5:0] FN_JR = 6'h08;
  localparam logic [5:0] FN_JALR = 6'h09;

  typedef enum logic [2:0] {
    CMP_EQ, CMP_NE, CMP_LTZ, CMP_GEZ, CMP_LEZ, CMP_GTZ
  } cmpKind_t;

  typedef struct packed {
    logic condBr;
    cmpKind_t cmp;
    logic regionJmp;
    logic regJmp;
    logic link;
  } npcStrobe_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] rtSel,
  output npcStrobe_t strobe
);
  always_comb begin
    strobe = '{condBr: 1'b0, cmp: CMP_EQ, regionJmp: 1'b0, regJmp: 1'b0, link: 1'b0};
    unique case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JR || funct == FN_JALR) strobe.regJmp = 1'b1;
        if (funct == FN_JALR) strobe.link = 1'b1;
      end
      OP_REGIMM: begin
        unique case (rtSel)
          5'd0, 5'd16: begin strobe.condBr = 1'b1; strobe.cmp = CMP_LTZ; end
          5'd1, 5'd17: begin strobe.condBr = 1'b1; strobe.cmp = CMP_GEZ; end
          default: ;
        endcase
        if (rtSel == 5'd16 || rtSel == 5'd17) strobe.link = 1'b1;
      end
      OP_J: strobe.regionJmp = 1'b1;
      OP_JAL: begin strobe.regionJmp = 1'b1; strobe.link = 1'b1; end
      OP_BEQ: begin strobe.condBr = 1'b1; strobe.cmp = CMP_EQ; end
      OP_BNE: begin strobe.condBr = 1'b1; strobe.cmp = CMP_NE; end
      OP_BLEZ: begin strobe.condBr = 1'b1; strobe.cmp = CMP_LEZ; end
      OP_BGTZ: begin strobe.condBr = 1'b1; strobe.cmp = CMP_GTZ; end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
(
  input  npcStrobe_t strobe,
  input  logic delaySlotEn,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [IMM_W-1:0] imm,
  input  logic [IDX_W-1:0] jIndex,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  output logic [ADDR_W-1:0] nextPcD,
  output logic takenD,
  output logic linkEnD,
  output logic [ADDR_W-1:0] linkAddrD
);
  localparam int REGION_W = ADDR_W - IDX_W - 2;
  localparam int EXT_W = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] seqPc, skipPc, brOffset, brTarget, regionTarget;
  logic rsNeg, rsZero, condMet;

  assign seqPc = curPc + ADDR_W'(STEP);
  assign skipPc = curPc + ADDR_W'(2 * STEP);
  assign brOffset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign brTarget = seqPc + brOffset;
  assign regionTarget = {curPc[ADDR_W-1 -: REGION_W], jIndex, 2'b00};

  assign rsNeg = rsVal[ADDR_W-1];
  assign rsZero = (rsVal == '0);

  always_comb begin
    unique case (strobe.cmp)
      CMP_EQ: condMet = (rsVal == rtVal);
      CMP_NE: condMet = (rsVal != rtVal);
      CMP_LTZ: condMet = rsNeg;
      CMP_GEZ: condMet = !rsNeg;
      CMP_LEZ: condMet = rsNeg || rsZero;
      CMP_GTZ: condMet = !rsNeg && !rsZero;
      default: condMet = 1'b0;
    endcase
  end

  always_comb begin
    takenD = 1'b1;
    if (strobe.regJmp) nextPcD = rsVal;
    else if (strobe.regionJmp) nextPcD = regionTarget;
    else if (strobe.condBr && condMet) nextPcD = brTarget;
    else begin
      nextPcD = seqPc;
      takenD = 1'b0;
    end
  end

  assign linkEnD = strobe.link;
  assign linkAddrD = delaySlotEn ? skipPc : seqPc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic delaySlotEn,
  input  logic [31:0] curPc,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] rtSel,
  input  logic [15:0] imm,
  input  logic [25:0] jIndex,
  input  logic [31:0] rsVal,
  input  logic [31:0] rtVal,
  output logic [31:0] nextPc,
  output logic taken,
  output logic linkEn,
  output logic [31:0] linkAddr
);
  npcStrobe_t strobe;
  logic [ADDR_W-1:0] nextPcD, linkAddrD;
  logic takenD, linkEnD;

  npc_ctrl uCtrl (
    .opcode(opcode), .funct(funct), .rtSel(rtSel), .strobe(strobe)
  );

  npc_datapath uPath (
    .strobe(strobe), .delaySlotEn(delaySlotEn), .curPc(curPc), .imm(imm),
    .jIndex(jIndex), .rsVal(rsVal), .rtVal(rtVal), .nextPcD(nextPcD),
    .takenD(takenD), .linkEnD(linkEnD), .linkAddrD(linkAddrD)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc <= '0;
      taken <= 1'b0;
      linkEn <= 1'b0;
      linkAddr <= '0;
    end else begin
      nextPc <= nextPcD;
      taken <= takenD;
      linkEn <= linkEnD;
      linkAddr <= linkAddrD;
    end
  end
endmodule

// File: rtl/npc_unit_checker.sv
module npc_unit_checker (
  input logic clk,
  input logic rstN,
  input logic delaySlotEn,
  input logic [31:0] curPc,
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic [31:0] rsVal,
  input logic [31:0] nextPc,
  input logic taken,
  input logic linkEn,
  input logic [31:0] linkAddr
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= rstN;

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !taken) |-> nextPc == $past(curPc) + 32'd4); // R1
  AST_REGION_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opcode) == 6'd2) |-> (taken && nextPc[31:28] == $past(curPc[31:28]) && nextPc[1:0] == 2'b00)); // R5
  AST_REG_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opcode) == 6'd0 && $past(funct) == 6'h08) |-> (taken && nextPc == $past(rsVal))); // R6
  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> linkAddr == $past(curPc) + ($past(delaySlotEn) ? 32'd8 : 32'd4)); // R8
  AST_NO_LINK_PLAIN: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opcode) == 6'd2) |-> !linkEn); // R7
endmodule

bind npc_unit npc_unit_checker uChk (
  .clk(clk), .rstN(rstN), .delaySlotEn(delaySlotEn), .curPc(curPc),
  .opcode(opcode), .funct(funct), .rsVal(rsVal), .nextPc(nextPc),
  .taken(taken), .linkEn(linkEn), .linkAddr(linkAddr)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic delaySlotEn = 1'b1;
  logic [31:0] curPc = '0, rsVal = '0, rtVal = '0;
  logic [5:0] opcode = '0, funct = '0;
  logic [4:0] rtSel = '0;
  logic [15:0] imm = '0;
  logic [25:0] jIndex = '0;
  logic [31:0] nextPc, linkAddr;
  logic taken, linkEn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rstN(rstN), .delaySlotEn(delaySlotEn), .curPc(curPc),
    .opcode(opcode), .funct(funct), .rtSel(rtSel), .imm(imm), .jIndex(jIndex),
    .rsVal(rsVal), .rtVal(rtVal), .nextPc(nextPc), .taken(taken),
    .linkEn(linkEn), .linkAddr(linkAddr)
  );

  logic [31:0] expPc, expLinkAddr;
  logic expTaken, expLink;
  string tag;

  function automatic void model();
    logic [31:0] seq;
    logic neg, zero, isBr, cond;
    seq = curPc + 32'd4;
    neg = rsVal[31];
    zero = (rsVal == 0);
    isBr = 1'b0;
    cond = 1'b0;
    expLink = 1'b0;
    expTaken = 1'b0;
    expPc = seq;
    tag = "R1";
    case (opcode)
      6'd0: if (funct == 6'h08 || funct == 6'h09) begin
        expTaken = 1'b1; expPc = rsVal; tag = "R6"; expLink = (funct == 6'h09);
      end else tag = "R10";
      6'd1: begin
        if (rtSel == 0 || rtSel == 16) begin isBr = 1; cond = neg; end
        else if (rtSel == 1 || rtSel == 17) begin isBr = 1; cond = !neg; end
        else tag = "R10";
        expLink = (rtSel == 16 || rtSel == 17);
        if (isBr) tag = "R3";
      end
      6'd2, 6'd3: begin
        expTaken = 1'b1; expPc = {curPc[31:28], jIndex, 2'b00}; tag = "R5";
        expLink = (opcode == 6'd3);
      end
      6'd4: begin isBr = 1; cond = (rsVal == rtVal); tag = "R2"; end
      6'd5: begin isBr = 1; cond = (rsVal != rtVal); tag = "R2"; end
      6'd6: begin isBr = 1; cond = neg || zero; tag = "R3"; end
      6'd7: begin isBr = 1; cond = !neg && !zero; tag = "R3"; end
      default: ;
    endcase
    if (isBr && cond) begin
      expTaken = 1'b1;
      expPc = seq + {{14{imm[15]}}, imm, 2'b00};
    end
    expLinkAddr = delaySlotEn ? curPc + 32'd8 : seq;
  endfunction

  task automatic checkOne(input string name, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", name, act, exp);
    end
  endtask

  // drive at negedge, sample just after the next posedge
  task automatic step();
    model();
    @(posedge clk);
    #1;
    checkOne({tag, " nextPc (R4 target/R1 seq)"}, nextPc, expPc);
    checkOne({tag, " taken"}, {31'd0, taken}, {31'd0, expTaken});
    checkOne("R7 linkEn", {31'd0, linkEn}, {31'd0, expLink});
    checkOne("R8 linkAddr", linkAddr, expLinkAddr);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pickVal();
    int s;
    s = $urandom_range(0, 9);
    case (s)
      0: return 32'd0;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'hFFFF_FFFF;
      4: return 32'd1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R9 reset state
    opcode = 6'd2; jIndex = 26'h3FF_FFFF; curPc = 32'h1234_5670;
    repeat (2) @(posedge clk);
    #1;
    checkOne("R9 reset nextPc", nextPc, 32'd0);
    checkOne("R9 reset taken", {31'd0, taken}, 32'd0);
    checkOne("R9 reset linkEn", {31'd0, linkEn}, 32'd0);
    checkOne("R9 reset linkAddr", linkAddr, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // directed corner cases
    opcode = 6'd8; curPc = 32'hFFFF_FFFC; step();              // R1 wrap
    opcode = 6'd4; curPc = 32'h0000_1000; rsVal = 5; rtVal = 5;
    imm = 16'h8000; step();                                    // R2 R4 most negative
    opcode = 6'd5; step();                                     // R2 not taken
    opcode = 6'd6; rsVal = 0; imm = 16'h0003; step();          // R3 zero boundary
    opcode = 6'd7; step();                                     // R3 zero not > 0
    opcode = 6'd1; rtSel = 5'd0; rsVal = 32'h8000_0000; step(); // R3 most negative
    rtSel = 5'd17; delaySlotEn = 1'b0; step();                 // R7 link, not taken, R8 PC+4
    rtSel = 5'd2; step();                                      // R10 unused selector
    opcode = 6'd3; curPc = 32'hF000_0040; jIndex = 26'h155_5555; step(); // R5 top region
    opcode = 6'd0; funct = 6'h09; rsVal = 32'hDEAD_BEE0; delaySlotEn = 1'b1; step(); // R6 JALR
    funct = 6'h0A; step();                                     // R10 other function

    for (int i = 0; i < 3000; i++) begin
      int o;
      o = $urandom_range(0, 11);
      opcode = (o < 8) ? 6'(o) : 6'($urandom_range(8, 63));
      o = $urandom_range(0, 3);
      funct = (o == 0) ? 6'h08 : (o == 1) ? 6'h09 : 6'($urandom);
      o = $urandom_range(0, 5);
      rtSel = (o == 0) ? 5'd0 : (o == 1) ? 5'd1 : (o == 2) ? 5'd16 : (o == 3) ? 5'd17 : 5'($urandom);
      rsVal = pickVal();
      rtVal = ($urandom_range(0, 3) == 0) ? rsVal : pickVal();
      curPc = {$urandom} & 32'hFFFF_FFFC;
      imm = 16'($urandom);
      jIndex = 26'($urandom);
      delaySlotEn = 1'($urandom);
      step();
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule